// File: doc/BRIEF.md
# Change-Triggered Key Matrix Scanner

This block watches a switch matrix of five row lines by six column lines. The column inputs are pulled up, so a low column means a closed switch on a row that is driven low. While nothing changes, every row output is held low. A press or a release therefore shows up directly on the column inputs, and no scanning is needed to see it. Once a change is seen, the block drives the rows low one at a time, builds a full 30-bit picture of the matrix and compares it with the picture last handed to the host. If the picture differs, it is latched as the reported snapshot. The interrupt output then goes low and a pending flag is raised.

The host reads the snapshot one row byte at a time through a byte select. It marks a read in progress with a busy level. A read that clears ends with a one-cycle clear pulse. This drops the interrupt and stops the scan. A read that does not clear is a busy window with no clear pulse, and it changes nothing. While an interrupt is pending, later key changes are held back. They raise a fresh interrupt as soon as the first one is cleared. In standby, any key activity produces a one-cycle wake request and runs the same scan-and-interrupt sequence. Leaving standby without key activity starts nothing.

Top module: `keymatrix_scanner`

## Requirements
- R1: After reset, and whenever the block is not scanning, all row outputs are 0, the interrupt output is 1 and the pending flag is 0.
- R2: A scan starts SYNC_STAGES+1 clocks after the column inputs stop matching the columns implied by the reported snapshot. During a scan, exactly one row output is 0 at a time, in the order row 0 up to row NUM_ROWS-1, each for ROW_CYCLES clocks.
- R3: At the end of a scan pass, if the pass differs from the reported snapshot, nothing is pending and no read is busy, the pass becomes the reported snapshot and the pending flag rises. The interrupt output goes low at the same time, SYNC_STAGES+1+NUM_ROWS*ROW_CYCLES clocks after the key change.
- R4: While an interrupt is pending, scanning continues and the reported snapshot does not change.
- R5: A clear pulse drops the pending flag and returns the interrupt output to 1 on the next clock. Scanning then stops unless the latest pass differs from the reported snapshot.
- R6: A busy window with no clear pulse leaves the pending flag, the interrupt output and the scanning unchanged.
- R7: A pass equal to the reported snapshot, with nothing pending, ends the scan without an interrupt. A key held through a clear causes no further scan or interrupt.
- R8: A key change made while an interrupt is pending raises a new interrupt after the clear, and the new snapshot contains both changes.
- R9: For byte select r below NUM_ROWS, data byte bit c (c = 0..NUM_COLS-1) is 1 when the switch at row r and column c is closed in the reported snapshot. The bits above NUM_COLS-1 are 0. A byte select of NUM_ROWS or more gives 0.
- R10: A pass that completes while busy is high does not update the snapshot or interrupt. The update happens on the first pass that completes after busy falls.
- R11: In standby, key activity gives exactly one wake pulse and the normal scan and interrupt. Entering and leaving standby with no key activity gives no wake pulse, no scan and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| col_n_i | input | NUM_COLS | Column sense inputs, low = closed switch on a driven row |
| row_o | output | NUM_ROWS | Row drives, 0 = row driven active |
| rd_busy_i | input | 1 | Host read in progress; blocks snapshot updates |
| rd_clear_i | input | 1 | One-cycle pulse ending a clearing read |
| byte_sel_i | input | $clog2(NUM_ROWS+1) | Row byte to present on data_o |
| data_o | output | BYTE_W | Selected row byte of the reported snapshot |
| pending_o | output | 1 | New snapshot waiting for a clearing read |
| kbint_n_o | output | 1 | Active-low interrupt request |
| standby_i | input | 1 | Device is in low-power standby |
| wake_o | output | 1 | One-cycle wake request caused by key activity in standby |

## Verification
Each of the 30 switches is pressed alone and then released. This exercises every column line and every row slot and checks the interrupt latency and the row order. A bit placed at the wrong position or a row scanned at the wrong time shows up as a byte mismatch. Two switches in one column on different rows show whether the snapshot comes from the scan rather than the idle column view. A second press during a pending interrupt separates a queued interrupt from one that is lost or that overwrites the first snapshot. Busy windows with and without a clear pulse, and standby entries with and without key activity, separate the clearing read from the non-clearing read and a key wake from a plain standby exit.

// File: rtl/kms_pkg.sv
package kms_pkg;

    // Controller phase: idle with every row driven, or stepping through rows.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } kms_state_e;

endpackage

// File: rtl/kms_col_sync.sv
// Multi-stage synchronizer for the column sense lines; idles released (all ones).
module kms_col_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_n_i,
    output logic [WIDTH-1:0] out_n_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = in_n_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign out_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/kms_row_timer.sv
// Steps the active row and the per-row dwell counter while run_i is high.
module kms_row_timer #(
    parameter int NUM_ROWS   = 5,
    parameter int ROW_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    output logic [RW-1:0]       row_idx_o,
    output logic                sample_o,
    output logic                pass_end_o
);

    localparam int RW = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
    localparam int CW = (ROW_CYCLES > 1) ? $clog2(ROW_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(ROW_CYCLES - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(NUM_ROWS - 1);

    typedef struct packed {
        logic [RW-1:0] row;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run_i) begin
            tmr_d = '0;
        end else if (tmr_q.cnt == CNT_LAST) begin
            tmr_d.cnt = '0;
            tmr_d.row = (tmr_q.row == ROW_LAST) ? '0 : tmr_q.row + 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign row_idx_o  = tmr_q.row;
    assign sample_o   = run_i && (tmr_q.cnt == CNT_LAST);
    assign pass_end_o = sample_o && (tmr_q.row == ROW_LAST);

endmodule

// File: rtl/kms_pass_buf.sv
// Collects one scan pass. All rows but the last are registered; the last row
// is passed through live so that a pass can be judged in its final cycle.
module kms_pass_buf #(
    parameter int NUM_ROWS = 5,
    parameter int NUM_COLS = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample_i,
    input  logic [RW-1:0]                row_idx_i,
    input  logic [NUM_COLS-1:0]          cols_closed_i,
    output logic [NUM_ROWS*NUM_COLS-1:0] pass_o
);

    localparam int RW = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        if (r < NUM_ROWS - 1) begin : g_reg
            logic [NUM_COLS-1:0] row_d, row_q;

            always_comb begin
                row_d = row_q;
                if (sample_i && (row_idx_i == RW'(r))) row_d = cols_closed_i;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) row_q <= '0;
                else        row_q <= row_d;
            end

            assign pass_o[r*NUM_COLS +: NUM_COLS] = row_q;
        end else begin : g_live
            assign pass_o[r*NUM_COLS +: NUM_COLS] = cols_closed_i;
        end
    end

endmodule

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner
    import kms_pkg::*;
#(
    parameter int NUM_ROWS    = 5,
    parameter int NUM_COLS    = 6,
    parameter int ROW_CYCLES  = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_COLS-1:0]             col_n_i,
    output logic [NUM_ROWS-1:0]             row_o,
    input  logic                            rd_busy_i,
    input  logic                            rd_clear_i,
    input  logic [$clog2(NUM_ROWS+1)-1:0]   byte_sel_i,
    output logic [BYTE_W-1:0]               data_o,
    output logic                            pending_o,
    output logic                            kbint_n_o,
    input  logic                            standby_i,
    output logic                            wake_o
);

    localparam int NBITS = NUM_ROWS * NUM_COLS;
    localparam int RW    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
    localparam int SEL_W = $clog2(NUM_ROWS + 1);
    localparam int STW   = $clog2(SYNC_STAGES + 1);
    localparam logic [STW-1:0] SETTLE_LOAD = STW'(SYNC_STAGES);

    typedef struct packed {
        kms_state_e       st;
        logic [STW-1:0]   settle;
        logic             pend;
        logic             wake;
        logic [NBITS-1:0] rep;
        logic [NBITS-1:0] last;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_COLS-1:0] col_sync_n;
    logic [NUM_COLS-1:0] col_any;
    logic [RW-1:0]       row_idx;
    logic                sample_stb;
    logic                pass_end;
    logic [NBITS-1:0]    pass_now;
    logic                idle_hit;
    logic                pass_diff;
    logic                scan_active;
    logic [NBITS-1:0]    rep_vec;

    kms_col_sync #(
        .WIDTH  (NUM_COLS),
        .STAGES (SYNC_STAGES)
    ) i_col_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_n_i  (col_n_i),
        .out_n_o (col_sync_n)
    );

    kms_row_timer #(
        .NUM_ROWS   (NUM_ROWS),
        .ROW_CYCLES (ROW_CYCLES)
    ) i_row_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (scan_active),
        .row_idx_o  (row_idx),
        .sample_o   (sample_stb),
        .pass_end_o (pass_end)
    );

    kms_pass_buf #(
        .NUM_ROWS (NUM_ROWS),
        .NUM_COLS (NUM_COLS)
    ) i_pass_buf (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_i      (sample_stb),
        .row_idx_i     (row_idx),
        .cols_closed_i (~col_sync_n),
        .pass_o        (pass_now)
    );

    // Columns that must read low while every row is driven, per the snapshot.
    always_comb begin
        col_any = '0;
        for (int r = 0; r < NUM_ROWS; r++) begin
            for (int c = 0; c < NUM_COLS; c++) begin
                col_any[c] = col_any[c] | ctl_q.rep[r*NUM_COLS + c];
            end
        end
    end

    assign idle_hit  = (ctl_q.settle == '0) && (col_sync_n != ~col_any);
    assign pass_diff = (pass_now != ctl_q.rep);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.wake = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (ctl_q.settle != '0) ctl_d.settle = ctl_q.settle - 1'b1;
                if (idle_hit) begin
                    ctl_d.st   = ST_SCAN;
                    ctl_d.wake = standby_i;
                end
            end
            ST_SCAN: begin
                if (pass_end) begin
                    ctl_d.last = pass_now;
                    if (!ctl_q.pend) begin
                        if (!pass_diff) begin
                            ctl_d.st     = ST_IDLE;
                            ctl_d.settle = SETTLE_LOAD;
                        end else if (!rd_busy_i) begin
                            ctl_d.rep  = pass_now;
                            ctl_d.pend = 1'b1;
                        end
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        // Clearing read: drop the request; keep scanning only for a queued change.
        if (rd_clear_i) begin
            ctl_d.pend = 1'b0;
            if ((ctl_q.st == ST_SCAN) && (ctl_d.last == ctl_d.rep)) begin
                ctl_d.st     = ST_IDLE;
                ctl_d.settle = SETTLE_LOAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign scan_active = (ctl_q.st == ST_SCAN);
    assign rep_vec     = ctl_q.rep;
    assign row_o       = scan_active ? ~(NUM_ROWS'(1) << row_idx) : '0;
    assign pending_o   = ctl_q.pend;
    assign kbint_n_o   = ~ctl_q.pend;
    assign wake_o      = ctl_q.wake;

    always_comb begin
        data_o = '0;
        for (int r = 0; r < NUM_ROWS; r++) begin
            if (byte_sel_i == SEL_W'(r)) data_o[NUM_COLS-1:0] = ctl_q.rep[r*NUM_COLS +: NUM_COLS];
        end
    end

endmodule

// File: rtl/kms_checker.sv
module kms_checker #(
    parameter int NUM_ROWS = 5,
    parameter int NUM_COLS = 6,
    parameter int BYTE_W   = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_ROWS-1:0]          row_o,
    input logic                         pending_o,
    input logic                         rd_clear_i,
    input logic                         rd_busy_i,
    input logic                         standby_i,
    input logic                         wake_o,
    input logic [BYTE_W-1:0]            data_o,
    input logic                         scan_i,
    input logic [NUM_ROWS*NUM_COLS-1:0] rep_i
);

    p_idle_rows_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_i |-> (row_o == '0));

    p_one_row_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_i |-> ($countones(row_o) == NUM_ROWS - 1));

    p_pending_scans_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o |-> scan_i);

    p_snapshot_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && $past(pending_o)) |-> (rep_i == $past(rep_i)));

    p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clear_i |=> !pending_o);

    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_o) |-> !$past(rd_busy_i));

    p_wake_in_standby_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(standby_i));

    p_wake_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    p_pad_bits_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_o >> NUM_COLS) == '0);

endmodule

bind keymatrix_scanner kms_checker #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS),
    .BYTE_W   (BYTE_W)
) i_kms_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_o      (row_o),
    .pending_o  (pending_o),
    .rd_clear_i (rd_clear_i),
    .rd_busy_i  (rd_busy_i),
    .standby_i  (standby_i),
    .wake_o     (wake_o),
    .data_o     (data_o),
    .scan_i     (scan_active),
    .rep_i      (rep_vec)
);

// File: tb/test_keymatrix_scanner.sv
module test_keymatrix_scanner;

    localparam int NR   = 5;
    localparam int NC   = 6;
    localparam int RC   = 8;
    localparam int SS   = 2;
    localparam int NB   = NR * NC;
    localparam int PASS = NR * RC;
    localparam int LAT  = SS + 1 + PASS;
    localparam int SW   = $clog2(NR + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] col_n;
    logic [NR-1:0] row_o;
    logic          rd_busy = 1'b0;
    logic          rd_clear = 1'b0;
    logic [SW-1:0] byte_sel = '0;
    logic [7:0]    data_o;
    logic          pending_o;
    logic          kbint_n_o;
    logic          standby = 1'b0;
    logic          wake_o;

    logic [NB-1:0] keys = '0;
    int n_chk = 0;
    int n_fail = 0;
    int scan_cnt = 0;
    int wake_cnt = 0;

    always #2 clk = ~clk;

    // Switch matrix model: a closed switch pulls its column low while its row is driven.
    always_comb begin
        col_n = '1;
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++)
                if (keys[r*NC + c] && !row_o[r]) col_n[c] = 1'b0;
    end

    always @(negedge clk) begin
        if (row_o != '0) scan_cnt <= scan_cnt + 1;
        if (wake_o)      wake_cnt <= wake_cnt + 1;
    end

    keymatrix_scanner i_keymatrix_scanner (
        .clk        (clk),
        .rst_n      (rst_n),
        .col_n_i    (col_n),
        .row_o      (row_o),
        .rd_busy_i  (rd_busy),
        .rd_clear_i (rd_clear),
        .byte_sel_i (byte_sel),
        .data_o     (data_o),
        .pending_o  (pending_o),
        .kbint_n_o  (kbint_n_o),
        .standby_i  (standby),
        .wake_o     (wake_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic read_check(input logic [NB-1:0] expv, input string req);
        for (int s = 0; s < NR; s++) begin
            byte_sel = SW'(s);
            #1;
            chk(data_o == 8'(expv[s*NC +: NC]), req, data_o, 8'(expv[s*NC +: NC]));
        end
        byte_sel = '0;
    endtask

    // Apply a key pattern at a falling edge and count clocks to the interrupt.
    task automatic press_wait(input logic [NB-1:0] nk, output int lat,
                              output logic [NR-1:0] r_pre, output logic [NR-1:0] r_a,
                              output logic [NR-1:0] r_b);
        int n = 0;
        @(negedge clk);
        keys = nk;
        lat = -1;
        r_pre = 'x; r_a = 'x; r_b = 'x;
        while (n < LAT + PASS) begin
            @(negedge clk);
            n++;
            if (n == SS)          r_pre = row_o;
            if (n == SS + 1)      r_a = row_o;
            if (n == SS + 1 + RC) r_b = row_o;
            if (!kbint_n_o) begin
                lat = n;
                break;
            end
        end
    endtask

    task automatic wait_int(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (!kbint_n_o) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        rd_busy = 1'b1;
        repeat (2) @(negedge clk);
        rd_clear = 1'b1;
        @(negedge clk);
        rd_clear = 1'b0;
        rd_busy = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int lat;
        int s0;
        int w0;
        bit seen;
        logic [NR-1:0] rp, ra, rb;
        logic [NB-1:0] ka, kb;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(row_o == '0, "R1 rows", row_o, 0);
        chk(kbint_n_o == 1'b1, "R1 kbint", kbint_n_o, 1);
        chk(pending_o == 1'b0, "R1 pending", pending_o, 0);
        chk(wake_o == 1'b0, "R1 wake", wake_o, 0);
        read_check('0, "R1 data");
        s0 = scan_cnt;
        repeat (50) @(negedge clk);
        chk(scan_cnt == s0, "R1 idle no scan", scan_cnt - s0, 0);

        // Sweep: every switch pressed alone, then released.
        for (int k = 0; k < NB; k++) begin
            press_wait(NB'(1) << k, lat, rp, ra, rb);
            chk(lat == LAT, "R3 latency press", lat, LAT);
            chk(rp == '0, "R2 rows before scan", rp, 0);
            chk(ra == NR'(~NR'(1)), "R2 first row", ra, NR'(~NR'(1)));
            chk(rb == NR'(~NR'(2)), "R2 second row", rb, NR'(~NR'(2)));
            chk(pending_o == 1'b1, "R3 pending", pending_o, 1);
            read_check(NB'(1) << k, "R9 single key");
            do_clear();
            chk(kbint_n_o == 1'b1, "R5 kbint cleared", kbint_n_o, 1);
            s0 = scan_cnt;
            repeat (60) @(negedge clk);
            chk(scan_cnt == s0, "R7 held key no rescan", scan_cnt - s0, 0);
            chk(kbint_n_o == 1'b1, "R7 held key no interrupt", kbint_n_o, 1);
            press_wait('0, lat, rp, ra, rb);
            chk(lat == LAT, "R3 latency release", lat, LAT);
            read_check('0, "R9 released");
            do_clear();
        end

        // Two switches sharing column 1, rows 0 and 2.
        ka = (NB'(1) << 1) | (NB'(1) << (2*NC + 1));
        press_wait(ka, lat, rp, ra, rb);
        chk(lat == LAT, "R3 shared column", lat, LAT);
        read_check(ka, "R9 shared column");
        do_clear();
        press_wait('0, lat, rp, ra, rb);
        do_clear();

        // Queued interrupt while pending.
        ka = NB'(1) << 0;
        kb = NB'(1) << (NC + 3);
        press_wait(ka, lat, rp, ra, rb);
        @(negedge clk);
        keys = ka | kb;
        s0 = scan_cnt;
        repeat (150) @(negedge clk);
        chk(kbint_n_o == 1'b0, "R8 still pending", kbint_n_o, 0);
        chk(scan_cnt - s0 == 150, "R4 scan while pending", scan_cnt - s0, 150);
        read_check(ka, "R4 snapshot frozen");
        do_clear();
        chk(kbint_n_o == 1'b1, "R8 first cleared", kbint_n_o, 1);
        wait_int(2*PASS + 10, seen);
        chk(seen, "R8 second interrupt", seen, 1);
        read_check(ka | kb, "R8 merged snapshot");
        do_clear();
        s0 = scan_cnt;
        repeat (60) @(negedge clk);
        chk(scan_cnt == s0, "R5 scan stopped", scan_cnt - s0, 0);
        press_wait('0, lat, rp, ra, rb);
        do_clear();

        // Non-clearing read and out-of-range byte selects.
        ka = NB'(1) << (4*NC + 5);
        press_wait(ka, lat, rp, ra, rb);
        @(negedge clk);
        rd_busy = 1'b1;
        repeat (5) @(negedge clk);
        rd_busy = 1'b0;
        @(negedge clk);
        chk(kbint_n_o == 1'b0, "R6 kbint kept", kbint_n_o, 0);
        chk(pending_o == 1'b1, "R6 pending kept", pending_o, 1);
        s0 = scan_cnt;
        repeat (40) @(negedge clk);
        chk(scan_cnt - s0 == 40, "R6 scan kept", scan_cnt - s0, 40);
        read_check(ka, "R6 data");
        for (int s = NR; s < (1 << SW); s++) begin
            byte_sel = SW'(s);
            #1;
            chk(data_o == 8'h00, "R9 select out of range", data_o, 0);
        end
        byte_sel = '0;
        do_clear();
        press_wait('0, lat, rp, ra, rb);
        do_clear();

        // Busy blocks the snapshot update.
        ka = NB'(1) << (3*NC + 2);
        @(negedge clk);
        rd_busy = 1'b1;
        keys = ka;
        repeat (150) @(negedge clk);
        chk(kbint_n_o == 1'b1, "R10 no interrupt while busy", kbint_n_o, 1);
        read_check('0, "R10 snapshot unchanged");
        @(negedge clk);
        rd_busy = 1'b0;
        wait_int(2*PASS + 10, seen);
        chk(seen, "R10 interrupt after busy", seen, 1);
        read_check(ka, "R10 snapshot after busy");
        do_clear();
        press_wait('0, lat, rp, ra, rb);
        do_clear();

        // Standby wake by key activity.
        @(negedge clk);
        standby = 1'b1;
        w0 = wake_cnt;
        ka = NB'(1) << (2*NC + 4);
        press_wait(ka, lat, rp, ra, rb);
        chk(lat == LAT, "R11 wake scan latency", lat, LAT);
        chk(wake_cnt - w0 == 1, "R11 one wake pulse", wake_cnt - w0, 1);
        read_check(ka, "R11 wake data");
        do_clear();
        standby = 1'b0;
        press_wait('0, lat, rp, ra, rb);
        do_clear();

        // Standby exit without key activity.
        repeat (10) @(negedge clk);
        w0 = wake_cnt;
        s0 = scan_cnt;
        standby = 1'b1;
        repeat (30) @(negedge clk);
        standby = 1'b0;
        repeat (100) @(negedge clk);
        chk(kbint_n_o == 1'b1, "R11 plain exit no interrupt", kbint_n_o, 1);
        chk(wake_cnt == w0, "R11 plain exit no wake", wake_cnt - w0, 0);
        chk(scan_cnt == s0, "R11 plain exit no scan", scan_cnt - s0, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule